// File: doc/BRIEF.md
# Single-Wire Serial Transmitter with Bus Collision Check

This block sends asynchronous frames over a bus that several stations share on one wire. It drives a frame of a start bit, DATA_BITS data bits sent least significant first, and one stop bit. At the same time it reads the line back and compares the level it receives with the level it drives. Whenever the two differ at a sampling moment, a sticky collision flag is raised. A configuration input picks the sampling moment: either the bit-rate tick or an external strobe from a one-shot timer.

The host loads a data word with a strobe and sets transmit enable. A frame can start in one of two ways. It can start on its own one bit period after it becomes ready, or it can wait for a falling logical edge on the receive line. Optionally, a collision withdraws transmit enable, and the frame in flight is dropped. One polarity input inverts both serial lines. All internal decisions use logical levels. Bit-rate generation, the receive data path and the one-shot timer belong to neighbouring blocks.

Top module: `sw_uart_tx`

## Requirements
- R1: A frame is logical 0 (start), then DATA_BITS data bits least significant bit first, then logical 1 (stop). Each bit holds from one `bit_tick` edge to the next. The idle line is logical 1.
- R2: With `cfg_samp_strobe`=0, driven and received logical levels are compared only in cycles where `bit_tick`=1. A mismatch in mid-bit is not flagged.
- R3: With `cfg_samp_strobe`=1, the comparison happens only in cycles where `samp_strobe`=1. Ticks alone never flag.
- R4: A mismatch at a sampling moment sets `coll_flag` at the next edge. The flag stays set until `coll_clr`=1 clears it. A new mismatch in the same cycle wins over the clear.
- R5: With `cfg_auto_drop`=1, the edge that sets the flag also clears `tx_en` and abandons the frame. The line is idle from that edge on.
- R6: No comparison happens while no frame is in progress, whatever `rxd`, `bit_tick` or `samp_strobe` do.
- R7: With `cfg_edge_start`=0, the block becomes ready when `tx_en`=1 and a word is loaded. The start bit then goes out at the second tick edge at which it is ready, one bit period after the first.
- R8: With `cfg_edge_start`=1, the start bit goes out at the clock edge that sees the logical receive level fall from 1 to 0 while the block is ready. That is the falling physical edge with normal polarity and the rising physical edge when inverted.
- R9: In edge-start mode, a receive edge that occurs before the block is ready does not start a frame, and it is not remembered.
- R10: `cfg_invert`=1 inverts `txd` and `rxd` (idle `txd` is then 0). The collision comparison uses the un-inverted levels.
- R11: `te_set`=1 sets `tx_en` and `te_clr`=1 clears it (clear wins). Clearing `tx_en` by any cause returns the line to idle at once and discards a loaded word. A frame then needs both a new `te_set` and a new `tx_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period (transfer clock edge) |
| tx_data | input | DATA_BITS | Word to send |
| tx_load | input | 1 | Stores `tx_data` into the holding register |
| te_set | input | 1 | Sets transmit enable |
| te_clr | input | 1 | Clears transmit enable |
| tx_en | output | 1 | Current transmit enable |
| cfg_samp_strobe | input | 1 | 0: compare on tick, 1: compare on `samp_strobe` |
| cfg_auto_drop | input | 1 | 1: collision clears transmit enable |
| cfg_edge_start | input | 1 | 1: wait for a receive-line edge before the start bit |
| cfg_invert | input | 1 | 1: invert both serial lines |
| txd | output | 1 | Serial line out |
| rxd | input | 1 | Serial line read back |
| samp_strobe | input | 1 | External sampling strobe (timer underflow) |
| coll_flag | output | 1 | Sticky collision flag |
| coll_clr | input | 1 | Write-one-to-clear for `coll_flag` |

## Verification
A wrong bit count or shift order shows on `txd` within one frame, as a start/stop misplacement or a wrong word at the scoreboard. A sampler listening on the wrong event raises or withholds `coll_flag` one edge away from the tick or strobe that should decide it, so the flag is checked mid-bit and right after the deciding edge. A start controller that arms too early or remembers an early edge starts the frame one bit period too soon, which the bench catches by counting ticks to the start bit. A lost enable or holding-register clear shows as a frame appearing where the line must stay idle.

// File: rtl/swu_pkg.sv
// Shared types for the single-wire transmitter.
// Assumes: configuration fields are only changed while the line is idle.
package swu_pkg;

    typedef struct packed {
        logic samp_on_strobe;  // compare on external strobe instead of tick
        logic auto_drop_en;    // collision withdraws transmit enable
        logic start_on_edge;   // start bit waits for a receive-line edge
        logic line_inv;        // both serial lines inverted
    } swu_cfg_t;

    // Total bits in one frame: start + data + stop.
    function automatic int unsigned swu_frame_len(input int unsigned data_bits);
        return data_bits + 2;
    endfunction

endpackage

// File: rtl/swu_enable_ctl.sv
// Transmit enable and one-word holding register.
// Holds the enable flag, stores a loaded word and reports when it is used.
// Assumes: a clear of enable, from software or from a collision, also discards the word.
module swu_enable_ctl #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 te_set,
    input  logic                 te_clr,
    input  logic                 auto_drop,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 consume,
    output logic                 te_q,
    output logic                 te_drop,
    output logic                 word_valid,
    output logic [DATA_BITS-1:0] word_q
);

    assign te_drop = te_clr | auto_drop;

    // Transmit enable: any clear has priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_q <= 1'b0;
        end else if (te_drop) begin
            te_q <= 1'b0;
        end else if (te_set) begin
            te_q <= 1'b1;
        end
    end

    // Holding register valid flag: discarded on drop, set on load, emptied on use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
        end else if (te_drop) begin
            word_valid <= 1'b0;
        end else if (load) begin
            word_valid <= 1'b1;
        end else if (consume) begin
            word_valid <= 1'b0;
        end
    end

    // Holding register data: captured on every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_data;
        end
    end

    AST_AUTO_DROP_CLEARS_TE: assert property (@(posedge clk) disable iff (!rst_n)
        auto_drop |=> !te_q); // R5

    AST_DROP_EMPTIES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        te_drop |=> !word_valid); // R11

endmodule

// File: rtl/swu_start_ctl.sv
// Start decision for a new frame.
// Tick mode: arms on the first tick seen while ready and fires on the next.
// Edge mode: fires on a logical 1->0 step of the receive level while ready.
// Assumes: rx_level is already in the logical (un-inverted) domain.
module swu_start_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ready,
    input  logic edge_mode,
    input  logic rx_level,
    output logic start
);

    logic armed_q;
    logic rx_prev_q;
    logic rx_fall;
    logic tick_go;

    assign rx_fall = rx_prev_q & ~rx_level;
    assign tick_go = tick & armed_q;
    assign start   = ready & (edge_mode ? rx_fall : tick_go);

    // Previous receive level, idle level after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev_q <= 1'b1;
        end else begin
            rx_prev_q <= rx_level;
        end
    end

    // Arm flag: one tick seen while ready; lost as soon as ready drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!ready || edge_mode) begin
            armed_q <= 1'b0;
        end else if (tick) begin
            armed_q <= 1'b1;
        end
    end

    AST_EDGE_START_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (start && edge_mode) |-> ($past(rx_level) && !rx_level)); // R8

endmodule

// File: rtl/swu_frame_seq.sv
// Frame sequencer: shifts start, data (LSB first) and stop bits, one per tick.
// Assumes: abort takes priority over start and over any tick.
module swu_frame_seq #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 start,
    input  logic                 abort,
    input  logic [DATA_BITS-1:0] word,
    output logic                 active,
    output logic                 drv_bit
);

    localparam int unsigned FRAME_LEN = swu_pkg::swu_frame_len(DATA_BITS);
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] shreg_q;
    logic [CNT_W-1:0]     cnt_q;

    assign drv_bit = shreg_q[0];

    // Frame state: load on start, advance on tick, stop after the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '1;
        end else if (abort) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '1;
        end else if (start) begin
            active  <= 1'b1;
            cnt_q   <= '0;
            shreg_q <= {1'b1, word, 1'b0};
        end else if (active && tick) begin
            if (cnt_q == LAST_BIT) begin
                active  <= 1'b0;
                cnt_q   <= '0;
                shreg_q <= '1;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                shreg_q <= {1'b1, shreg_q[FRAME_LEN-1:1]};
            end
        end
    end

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> !drv_bit); // R1

    AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt_q == LAST_BIT) |-> drv_bit); // R1

endmodule

// File: rtl/swu_coll_det.sv
// Collision sampler and sticky flag.
// Compares driven and received logical levels on the selected sampling event.
// Assumes: both levels arrive un-inverted; compares only while a frame runs.
module swu_coll_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic strobe,
    input  logic samp_on_strobe,
    input  logic active,
    input  logic drv_bit,
    input  logic rx_level,
    input  logic flag_clr,
    output logic hit,
    output logic flag_q
);

    logic sample_evt;

    assign sample_evt = samp_on_strobe ? strobe : tick;
    assign hit        = sample_evt & active & (drv_bit ^ rx_level);

    // Sticky flag: a new hit wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q); // R4

    AST_FLAG_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(active)); // R6

    AST_STROBE_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && $past(samp_on_strobe)) |-> $past(strobe)); // R3

    AST_TICK_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && !$past(samp_on_strobe)) |-> $past(tick)); // R2

endmodule

// File: rtl/sw_uart_tx.sv
// Single-wire serial transmitter with read-back collision check (top).
// Applies line polarity at the edge, so all internal logic uses logical levels.
// Assumes: bit_tick is a one-cycle pulse; configuration changes only while idle.
module sw_uart_tx #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_load,
    input  logic                 te_set,
    input  logic                 te_clr,
    output logic                 tx_en,
    input  logic                 cfg_samp_strobe,
    input  logic                 cfg_auto_drop,
    input  logic                 cfg_edge_start,
    input  logic                 cfg_invert,
    output logic                 txd,
    input  logic                 rxd,
    input  logic                 samp_strobe,
    output logic                 coll_flag,
    input  logic                 coll_clr
);

    import swu_pkg::*;

    swu_cfg_t             cfg;
    logic                 rx_level;
    logic                 te_drop;
    logic                 auto_drop;
    logic                 word_valid;
    logic [DATA_BITS-1:0] word;
    logic                 ready;
    logic                 start;
    logic                 active;
    logic                 drv_bit;
    logic                 hit;
    logic                 line_level;

    assign cfg = '{samp_on_strobe: cfg_samp_strobe,
                   auto_drop_en:   cfg_auto_drop,
                   start_on_edge:  cfg_edge_start,
                   line_inv:       cfg_invert};

    assign rx_level   = rxd ^ cfg.line_inv;
    assign auto_drop  = hit & cfg.auto_drop_en;
    assign ready      = tx_en & word_valid & ~active;
    assign line_level = active ? drv_bit : 1'b1;
    assign txd        = line_level ^ cfg.line_inv;

    swu_enable_ctl #(.DATA_BITS(DATA_BITS)) u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .te_set     (te_set),
        .te_clr     (te_clr),
        .auto_drop  (auto_drop),
        .load       (tx_load),
        .load_data  (tx_data),
        .consume    (start),
        .te_q       (tx_en),
        .te_drop    (te_drop),
        .word_valid (word_valid),
        .word_q     (word)
    );

    swu_start_ctl u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .ready     (ready),
        .edge_mode (cfg.start_on_edge),
        .rx_level  (rx_level),
        .start     (start)
    );

    swu_frame_seq #(.DATA_BITS(DATA_BITS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .start   (start),
        .abort   (te_drop),
        .word    (word),
        .active  (active),
        .drv_bit (drv_bit)
    );

    swu_coll_det u_coll (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (bit_tick),
        .strobe         (samp_strobe),
        .samp_on_strobe (cfg.samp_on_strobe),
        .active         (active),
        .drv_bit        (drv_bit),
        .rx_level       (rx_level),
        .flag_clr       (coll_clr),
        .hit            (hit),
        .flag_q         (coll_flag)
    );

    AST_IDLE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !active); // R11

    AST_LAUNCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(tx_en)); // R7

endmodule

// File: tb/test_sw_uart_tx.sv
module test_sw_uart_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       te_set = 1'b0;
    logic       te_clr = 1'b0;
    logic       tx_en;
    logic       cfg_samp_strobe = 1'b0;
    logic       cfg_auto_drop = 1'b0;
    logic       cfg_edge_start = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       txd;
    logic       rxd;
    logic       samp_strobe = 1'b0;
    logic       coll_flag;
    logic       coll_clr = 1'b0;

    logic       ovr_en = 1'b0;
    logic       ovr_val = 1'b1;
    logic       mon_en = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    assign rxd = ovr_en ? ovr_val : txd;

    always #5 clk = ~clk;

    sw_uart_tx i_sw_uart_tx (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_tick        (bit_tick),
        .tx_data         (tx_data),
        .tx_load         (tx_load),
        .te_set          (te_set),
        .te_clr          (te_clr),
        .tx_en           (tx_en),
        .cfg_samp_strobe (cfg_samp_strobe),
        .cfg_auto_drop   (cfg_auto_drop),
        .cfg_edge_start  (cfg_edge_start),
        .cfg_invert      (cfg_invert),
        .txd             (txd),
        .rxd             (rxd),
        .samp_strobe     (samp_strobe),
        .coll_flag       (coll_flag),
        .coll_clr        (coll_clr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic lv();
        return txd ^ cfg_invert;
    endfunction

    // Tick generator: one-cycle pulse every 4 clocks, driven after the edge.
    initial begin
        int div = 0;
        forever begin
            @(posedge clk);
            #1;
            div = (div == 3) ? 0 : div + 1;
            bit_tick = (div == 3);
        end
    end

    // Monitor: samples each bit just before the tick that ends it, pops the scoreboard.
    initial begin
        bit       in_frame = 1'b0;
        int       nbit = 0;
        logic [7:0] acc = '0;
        forever begin
            @(negedge clk);
            if (!mon_en) begin
                in_frame = 1'b0;
            end else if (bit_tick) begin
                if (!in_frame) begin
                    if (!lv()) begin
                        in_frame = 1'b1;
                        nbit = 0;
                        acc = '0;
                    end
                end else if (nbit < 8) begin
                    acc[nbit] = lv();
                    nbit++;
                end else begin
                    in_frame = 1'b0;
                    chk(lv() == 1'b1, "R1 stop bit", lv(), 1);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1 unexpected frame", acc, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(acc == e, "R1 frame data", acc, e);
                    end
                end
            end
        end
    end

    task automatic pulse_load(input logic [7:0] d);
        @(posedge clk); #1; tx_data = d; tx_load = 1'b1;
        @(posedge clk); #1; tx_load = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        exp_q.push_back(d);
        pulse_load(d);
    endtask

    task automatic pulse_te_set();
        @(posedge clk); #1; te_set = 1'b1;
        @(posedge clk); #1; te_set = 1'b0;
    endtask

    task automatic pulse_te_clr();
        @(posedge clk); #1; te_clr = 1'b1;
        @(posedge clk); #1; te_clr = 1'b0;
    endtask

    task automatic pulse_cclr();
        @(posedge clk); #1; coll_clr = 1'b1;
        @(posedge clk); #1; coll_clr = 1'b0;
    endtask

    task automatic pulse_strobe();
        @(posedge clk); #1; samp_strobe = 1'b1;
        @(posedge clk); #1; samp_strobe = 1'b0;
    endtask

    // Ends at the negedge right after a tick edge.
    task automatic next_tick();
        do @(negedge clk); while (!bit_tick);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) next_tick();
    endtask

    task automatic wait_start_bit();
        do @(negedge clk); while (lv() != 1'b0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 idle after reset", txd, 1);
        chk(tx_en == 1'b0, "R11 enable off after reset", tx_en, 0);
        chk(coll_flag == 1'b0, "R4 flag clear after reset", coll_flag, 0);

        // R7: tick start, one bit period after ready
        mon_en = 1'b1;
        pulse_te_set();
        send(8'hA5);
        next_tick();
        chk(lv() == 1'b1, "R7 no start on arming tick", lv(), 1);
        next_tick();
        chk(lv() == 1'b0, "R7 start on second tick", lv(), 0);
        drain();

        // R1: several data patterns through the scoreboard
        send(8'h00); drain();
        send(8'hFF); drain();
        send(8'h3C); drain();
        send(8'h81); drain();
        chk(coll_flag == 1'b0, "R2 no collision on clean loopback", coll_flag, 0);

        // R6: mismatching line and strobes while idle
        @(posedge clk); #1; ovr_en = 1'b1; ovr_val = 1'b0;
        ticks(3);
        @(posedge clk); #1; cfg_samp_strobe = 1'b1;
        pulse_strobe();
        ticks(1);
        chk(coll_flag == 1'b0, "R6 no compare while idle", coll_flag, 0);
        @(posedge clk); #1; cfg_samp_strobe = 1'b0; ovr_val = 1'b1;

        // R2/R4: tick sampling, sticky flag, write-one clear
        mon_en = 1'b0;
        pulse_load(8'hFF);
        wait_start_bit();
        chk(coll_flag == 1'b0, "R2 no flag mid-bit", coll_flag, 0);
        next_tick();
        chk(coll_flag == 1'b1, "R2 flag at tick on start-bit mismatch", coll_flag, 1);
        chk(tx_en == 1'b1, "R5 enable kept without auto drop", tx_en, 1);
        ticks(2);
        chk(coll_flag == 1'b1, "R4 flag sticky", coll_flag, 1);
        pulse_cclr();
        @(negedge clk);
        chk(coll_flag == 1'b0, "R4 flag cleared by write one", coll_flag, 0);
        ticks(10);

        // R3: strobe sampling
        @(posedge clk); #1; cfg_samp_strobe = 1'b1;
        pulse_load(8'h00);
        wait_start_bit();
        ticks(3);
        chk(coll_flag == 1'b0, "R3 ticks do not sample", coll_flag, 0);
        pulse_strobe();
        @(negedge clk);
        chk(coll_flag == 1'b1, "R3 strobe samples mismatch", coll_flag, 1);
        pulse_cclr();
        ticks(10);
        @(posedge clk); #1; cfg_samp_strobe = 1'b0;

        // R5: auto drop on collision
        @(posedge clk); #1; cfg_auto_drop = 1'b1;
        pulse_load(8'hFF);
        wait_start_bit();
        next_tick();
        chk(coll_flag == 1'b1, "R5 flag set", coll_flag, 1);
        chk(tx_en == 1'b0, "R5 enable withdrawn", tx_en, 0);
        chk(lv() == 1'b1, "R5 frame abandoned", lv(), 1);
        ticks(2);
        chk(lv() == 1'b1, "R5 line stays idle", lv(), 1);
        pulse_cclr();
        @(posedge clk); #1; cfg_auto_drop = 1'b0; ovr_en = 1'b0;

        // R11: enable alone does not restart; a fresh load does
        pulse_te_set();
        ticks(3);
        chk(lv() == 1'b1, "R11 no frame without fresh load", lv(), 1);
        mon_en = 1'b1;
        send(8'h5A);
        drain();

        // R11: enable cleared mid-frame
        mon_en = 1'b0;
        pulse_load(8'h00);
        wait_start_bit();
        next_tick();
        pulse_te_clr();
        @(negedge clk);
        chk(lv() == 1'b1, "R11 idle right after enable clear", lv(), 1);
        chk(tx_en == 1'b0, "R11 enable reads cleared", tx_en, 0);
        ticks(2);
        chk(lv() == 1'b1, "R11 stays idle", lv(), 1);

        // R9/R8: edge start, normal polarity
        mon_en = 1'b1;
        @(posedge clk); #1; cfg_edge_start = 1'b1; ovr_en = 1'b1; ovr_val = 1'b1;
        @(posedge clk); #1; ovr_val = 1'b0;
        @(posedge clk); #1; ovr_val = 1'b1;
        pulse_te_set();
        send(8'hC3);
        ticks(3);
        chk(lv() == 1'b1, "R9 early edge ignored", lv(), 1);
        @(posedge clk); #1; ovr_val = 1'b0;
        @(posedge clk); #1; ovr_en = 1'b0; ovr_val = 1'b1;
        @(negedge clk);
        chk(lv() == 1'b0, "R8 start on falling edge", lv(), 0);
        drain();

        // R10/R8: inverted polarity, rising physical edge starts
        @(posedge clk); #1; cfg_invert = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R10 inverted idle level", txd, 0);
        @(posedge clk); #1; ovr_en = 1'b1; ovr_val = 1'b0;
        send(8'h96);
        next_tick();
        chk(lv() == 1'b1, "R8 inverted waits for edge", lv(), 1);
        @(posedge clk); #1; ovr_val = 1'b1;
        @(posedge clk); #1; ovr_en = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R10 R8 start on rising physical edge", txd, 1);
        drain();
        chk(coll_flag == 1'b0, "R10 logical compare under inversion", coll_flag, 0);

        summary();
        $finish;
    end

endmodule